// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a scalar floating-point unit. Software writes and reads it over a simple register port. The word carries five sticky exception flags, five trap-enable bits, a 3-bit rounding-mode field and a compare-condition bit. The block supplies a 2-bit rounding mode to the arithmetic datapath. It collects per-operation exception pulses from that datapath into the sticky flags. It records the outcome of compare operations in the condition bit.

Software may write a rounding code that the datapath cannot honour. In that case the block stores the code, keeps the datapath on its previous mode and pulses an error output. The rounding output is reloaded only when a write actually changes the rounding field. The accumulated flags are kept apart from the stored word and are merged in only on the read path. Every write reloads the accumulated flags from the trap-enable bits of the written value.

Top module: `fpscr_unit`

## Requirements
- R1: After reset, rdData reads 0, roundMode is 0 (round to nearest even) and badRound is low.
- R2: A write stores wrData masked to bits [12:0] and bit 29, readable on rdData from the next cycle; all other rdData bits always read 0.
- R3: rdData bits [4:0] are the stored flag bits [4:0] ORed with the accumulated exception flags.
- R4: Every write reloads the accumulated flags from wrData bits [9:5] (trap-enable field), mapped bit for bit onto flags [4:0].
- R5: When no write happens, excPulse bits (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact) OR into the accumulated flags, which hold until the next write.
- R6: A write in the same cycle as an exception pulse takes priority, and the pulse is lost.
- R7: Rounding field wrData[12:10] codes 0..3 decode to roundMode 0 = nearest even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf, which is valid in the cycle after the write.
- R8: A write with rounding code 4 or above that changes the field stores the code and raises badRound for exactly one cycle after the write, and roundMode keeps its old value.
- R9: A write whose rounding field equals the stored field leaves roundMode unchanged and does not raise badRound, even when the code is unsupported.
- R10: roundMode changes only in the cycle after a write.
- R11: When cmpValid is high and no write happens, bit 29 takes cmpFlag in the next cycle; a simultaneous write sets bit 29 from wrData instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Register read value with flags merged |
| excPulse | input | 5 | Per-cycle exception pulses from the datapath |
| cmpValid | input | 1 | Compare result strobe |
| cmpFlag | input | 1 | Compare result value |
| roundMode | output | 2 | Rounding mode to the datapath |
| badRound | output | 1 | One-cycle pulse on an unsupported rounding write |

## Verification
The bench writes an unsupported rounding code twice in a row. A design that checked the written code rather than the change would pulse badRound on the repeat, and one that loaded the code anyway would move roundMode. It writes with non-zero trap enables and expects them echoed as flags; a design that cleared or preserved the flags on write reads back the wrong low bits. It also collides a write with an exception pulse and with a compare strobe. A design that gave the datapath priority would keep the pulsed flag or the compare bit.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAG_W   = 5;
  localparam int FLAG_LSB = 0;
  localparam int TRAP_LSB = FLAG_LSB + FLAG_W;
  localparam int RND_W    = 3;
  localparam int RND_LSB  = TRAP_LSB + FLAG_W;
  localparam int MODE_W   = 2;
  localparam int CMP_BIT  = 29;

  function automatic logic [DATA_W-1:0] buildMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < RND_LSB + RND_W; i++) m[i] = 1'b1;
    m[CMP_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] WR_MASK = buildMask();

  typedef enum logic [MODE_W-1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_POS  = 2'd2,
    RND_NEG  = 2'd3
  } rndMode_t;

  typedef struct packed {
    logic loadAll;
    logic accumFlags;
    logic setCmp;
    logic updRound;
    logic raiseErr;
  } fpscrStrb_t;
endpackage

// File: rtl/fpscr_ctrl.sv
module fpscr_ctrl
  import fpscr_pkg::*;
(
  input  logic             wrEn,
  input  logic [RND_W-1:0] wrRnd,
  input  logic [RND_W-1:0] curRnd,
  input  logic             cmpValid,
  output fpscrStrb_t       strb,
  output rndMode_t         nextRound
);
  localparam int SUPPORTED = 4;

  logic rndChanged;
  logic rndLegal;

  function automatic rndMode_t rndDecode(input logic [RND_W-1:0] code);
    rndMode_t r;
    case (code)
      3'd0:    r = RND_NEAR;
      3'd1:    r = RND_ZERO;
      3'd2:    r = RND_POS;
      3'd3:    r = RND_NEG;
      default: r = RND_NEAR;
    endcase
    return r;
  endfunction

  always_comb begin
    rndChanged = wrEn && ((wrRnd ^ curRnd) != '0);
    rndLegal   = (int'(wrRnd) < SUPPORTED);
    nextRound  = rndDecode(wrRnd);

    strb.loadAll    = wrEn;
    strb.accumFlags = !wrEn;
    strb.setCmp     = cmpValid && !wrEn;
    strb.updRound   = rndChanged && rndLegal;
    strb.raiseErr   = rndChanged && !rndLegal;
  end
endmodule

// File: rtl/fpscr_dp.sv
module fpscr_dp
  import fpscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpscrStrb_t        strb,
  input  rndMode_t          nextRound,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_W-1:0] excPulse,
  input  logic              cmpFlag,
  output logic [RND_W-1:0]  curRnd,
  output logic [DATA_W-1:0] rdData,
  output logic [MODE_W-1:0] roundMode,
  output logic              badRound
);
  logic [DATA_W-1:0] imgQ;
  logic [FLAG_W-1:0] stickyQ;
  rndMode_t          roundQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imgQ    <= '0;
      stickyQ <= '0;
      roundQ  <= RND_NEAR;
      errQ    <= 1'b0;
    end else begin
      if (strb.loadAll)     imgQ <= wrData & WR_MASK;
      else if (strb.setCmp) imgQ[CMP_BIT] <= cmpFlag;

      if (strb.loadAll)         stickyQ <= wrData[TRAP_LSB +: FLAG_W];
      else if (strb.accumFlags) stickyQ <= stickyQ | excPulse;

      if (strb.updRound) roundQ <= nextRound;
      errQ <= strb.raiseErr;
    end
  end

  assign curRnd    = imgQ[RND_LSB +: RND_W];
  assign rdData    = (imgQ & WR_MASK) | {{(DATA_W-FLAG_W){1'b0}}, stickyQ};
  assign roundMode = roundQ;
  assign badRound  = errQ;
endmodule

// File: rtl/fpscr_unit.sv
module fpscr_unit
  import fpscr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [FLAG_W-1:0] excPulse,
  input  logic              cmpValid,
  input  logic              cmpFlag,
  output logic [MODE_W-1:0] roundMode,
  output logic              badRound
);
  fpscrStrb_t       strb;
  rndMode_t         nextRound;
  logic [RND_W-1:0] curRnd;

  fpscr_ctrl uCtrl (
    .wrEn      (wrEn),
    .wrRnd     (wrData[RND_LSB +: RND_W]),
    .curRnd    (curRnd),
    .cmpValid  (cmpValid),
    .strb      (strb),
    .nextRound (nextRound)
  );

  fpscr_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .nextRound (nextRound),
    .wrData    (wrData),
    .excPulse  (excPulse),
    .cmpFlag   (cmpFlag),
    .curRnd    (curRnd),
    .rdData    (rdData),
    .roundMode (roundMode),
    .badRound  (badRound)
  );
endmodule

// File: rtl/fpscr_unit_chk.sv
module fpscr_unit_chk
  import fpscr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [FLAG_W-1:0] excPulse,
  input logic              cmpValid,
  input logic              cmpFlag,
  input logic [MODE_W-1:0] roundMode,
  input logic              badRound
);
  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[RND_LSB+RND_W-1:TRAP_LSB] == $past(wrData[RND_LSB+RND_W-1:TRAP_LSB]))
             && (rdData[CMP_BIT] == $past(wrData[CMP_BIT]))); // R2

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ((rdData & ~WR_MASK) == '0)); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((rdData[FLAG_W-1:0] & $past(rdData[FLAG_W-1:0])) == $past(rdData[FLAG_W-1:0]))); // R5

  AST_PULSE_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && excPulse != '0) |=> ((rdData[FLAG_W-1:0] & $past(excPulse)) == $past(excPulse))); // R5

  AST_RND_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(roundMode)); // R10

  AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    badRound |-> $past(wrEn)); // R8

  AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    badRound |-> $stable(roundMode)); // R8

  AST_CMP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !wrEn) |=> (rdData[CMP_BIT] == $past(cmpFlag))); // R11
endmodule

bind fpscr_unit fpscr_unit_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .excPulse  (excPulse),
  .cmpValid  (cmpValid),
  .cmpFlag   (cmpFlag),
  .roundMode (roundMode),
  .badRound  (badRound)
);

// File: tb/fpscr_unit_test.sv
module fpscr_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [4:0]  excPulse = '0;
  logic        cmpValid = 1'b0;
  logic        cmpFlag = 1'b0;
  logic [1:0]  roundMode;
  logic        badRound;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fpscr_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .excPulse(excPulse), .cmpValid(cmpValid), .cmpFlag(cmpFlag),
    .roundMode(roundMode), .badRound(badRound)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [4:0] p = '0,
                         input logic cv = 1'b0, input logic cf = 1'b0);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; excPulse = p; cmpValid = cv; cmpFlag = cf;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; excPulse = '0; cmpValid = 1'b0; cmpFlag = 1'b0;
  endtask

  task automatic idleCycle(input logic [4:0] p = '0, input logic cv = 1'b0,
                           input logic cf = 1'b0);
    @(negedge clk);
    excPulse = p; cmpValid = cv; cmpFlag = cf;
    @(negedge clk);
    excPulse = '0; cmpValid = 1'b0; cmpFlag = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdData", rdData, 32'h0);
    check("R1 roundMode", {30'b0, roundMode}, 32'h0);
    check("R1 badRound", {31'b0, badRound}, 32'h0);
  endtask

  task automatic testStoreMask();
    doWrite(32'hFFFF_FFFF);
    check("R2 masked store", rdData, 32'h2000_1FFF);
    check("R8 code7 err", {31'b0, badRound}, 32'h1);
    check("R8 code7 mode kept", {30'b0, roundMode}, 32'h0);
    idleCycle();
    check("R8 err one cycle", {31'b0, badRound}, 32'h0);
    doWrite(32'h0);
    check("R2 clear", rdData, 32'h0);
  endtask

  task automatic testDecode();
    for (int c = 1; c <= 4; c++) begin
      doWrite(32'((c % 4) << 10));
      check("R7 decode", {30'b0, roundMode}, 32'(c % 4));
      check("R7 no err", {31'b0, badRound}, 32'h0);
    end
  endtask

  task automatic testTrapReload();
    doWrite(32'h0000_02A0);
    check("R4 reload", rdData, 32'h0000_02B5);
    doWrite(32'h0);
    check("R4 reload zero", rdData, 32'h0);
  endtask

  task automatic testAccumulate();
    idleCycle(5'h01);
    idleCycle(5'h04);
    check("R5 accumulate", rdData, 32'h5);
    idleCycle();
    check("R5 hold", rdData, 32'h5);
    doWrite(32'h0, 5'h1F);
    check("R6 write wins", rdData, 32'h0);
  endtask

  task automatic testMerge();
    doWrite(32'h3);
    check("R3 stored flags", rdData, 32'h3);
    idleCycle(5'h10);
    check("R3 merge", rdData, 32'h13);
    doWrite(32'h0);
  endtask

  task automatic testReject();
    doWrite(32'h800);
    check("R7 mode2", {30'b0, roundMode}, 32'h2);
    doWrite(32'h1000);
    check("R8 code4 err", {31'b0, badRound}, 32'h1);
    check("R8 code4 mode kept", {30'b0, roundMode}, 32'h2);
    check("R8 code4 stored", rdData, 32'h1000);
    doWrite(32'h1000);
    check("R9 repeat no err", {31'b0, badRound}, 32'h0);
    check("R9 repeat mode", {30'b0, roundMode}, 32'h2);
    doWrite(32'h1400);
    check("R8 code5 err", {31'b0, badRound}, 32'h1);
    doWrite(32'hC00);
    check("R7 mode3 after reject", {30'b0, roundMode}, 32'h3);
    doWrite(32'hC00);
    check("R9 same legal", {30'b0, roundMode}, 32'h3);
    idleCycle();
    check("R10 idle keeps mode", {30'b0, roundMode}, 32'h3);
    doWrite(32'h0);
    check("R7 back to nearest", {30'b0, roundMode}, 32'h0);
  endtask

  task automatic testCompare();
    idleCycle(5'h0, 1'b1, 1'b1);
    check("R11 cmp set", rdData, 32'h2000_0000);
    idleCycle(5'h0, 1'b1, 1'b0);
    check("R11 cmp clear", rdData, 32'h0);
    doWrite(32'h2000_0000, 5'h0, 1'b1, 1'b0);
    check("R11 write wins", rdData, 32'h2000_0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testStoreMask();
        testDecode();
        testTrapReload();
        testAccumulate();
        testMerge();
        testReject();
        testCompare();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule